// File: doc/BRIEF.md
# Next-Line Index Predictor

This block keeps one predicted successor index for every fetch line of an instruction cache. In each cycle it looks up the entry of the line being fetched and presents that entry as the fetch index in the following cycle. A line that ends in a taken branch can therefore be followed by its target line with no idle cycle, once the entry has learned that target.

When the cache fills a line, the fill port rewrites that line's entry to the next sequential line, so a freshly filled line first predicts fall-through. A slower branch predictor later computes the true next line for a fetched line and offers it on the compare port. If it disagrees with the stored entry, the block raises a squash flag for the current fetch, sends fetch to the predictor's line on the next cycle, and writes the predictor's line into the entry. The cache data arrays and the branch predictor are outside this block.

Top module: `nlp_predictor`

## Requirements
- R1: While `rst_n` is low at a clock edge, `fetch_idx` becomes `RESET_IDX` (default 0) and every entry i becomes (i+1) modulo `NUM_LINES`. With no fills and no compare traffic after reset, fetch therefore walks 0, 1, 2, ... in order.
- R2: In a cycle where `squash` is low, `fetch_idx` after the next clock edge equals the entry stored for the current `fetch_idx`.
- R3: A fill (`fill_valid` high) at a clock edge writes (`fill_idx`+1) modulo `NUM_LINES` into the entry of `fill_idx`.
- R4: `squash` is high in the same cycle, combinationally, exactly when `bp_valid` is high and `bp_next` differs from the entry stored for `bp_line`. After the next clock edge `fetch_idx` equals that `bp_next`.
- R5: When `squash` is high at a clock edge, the entry of `bp_line` is rewritten to `bp_next`, unless a fill targets the same line in that cycle.
- R6: When `bp_valid` is high and `bp_next` equals the stored entry, `squash` stays low, no entry changes and fetch follows the stored entry.
- R7: When a fill and a retrain target the same line in one cycle, the entry takes the fill value (the sequential successor).
- R8: The sequential successor of the last line, `NUM_LINES`-1, is line 0, both after reset and on a fill.
- R9: While `bp_valid` is low, `bp_line` and `bp_next` are ignored: `squash` stays low and no entry is retrained.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| fill_valid | input | 1 | A line fill happens this cycle |
| fill_idx | input | IDX_W | Index of the line being filled |
| bp_valid | input | 1 | The branch predictor offers a next line this cycle |
| bp_line | input | IDX_W | Line whose entry is being checked |
| bp_next | input | IDX_W | Next line computed by the branch predictor |
| fetch_idx | output | IDX_W | Line index fetched in this cycle |
| squash | output | 1 | The line fetched in this cycle is wrong and must be discarded |

## Verification
The assertions take for granted that every index driven on `fill_idx`, `bp_line` and `bp_next` lies below `NUM_LINES`, and that the inputs are stable around the rising edge. The stimulus draws all indices in the range 0 to `NUM_LINES`-1 and changes inputs only on the falling edge. Within that range it mixes idle cycles, agreeing and disagreeing compares, fills, and same-line fill and retrain collisions. A behavioural model of the table in the bench predicts `squash` and `fetch_idx` for every cycle.

// File: rtl/nlp_pkg.sv
// Package nlp_pkg
// Shared definitions for the next-line index predictor: the write source
// selector for a table entry and the sequential successor function.
// Assumes indices passed to seq_next are below the table size.
package nlp_pkg;

    // Which source updates a table entry in a given cycle.
    typedef enum logic [1:0] {
        WR_NONE    = 2'd0,
        WR_FILL    = 2'd1,
        WR_RETRAIN = 2'd2
    } wr_src_e;

    // Sequential successor of a line, wrapping at the table size.
    function automatic int unsigned seq_next(input int unsigned idx,
                                             input int unsigned lines);
        return (idx + 1 >= lines) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/nlp_table.sv
// Module nlp_table
// Storage for one predicted next-line index per fetch line. Each entry is
// rewritten by a fill (sequential successor) or by a retrain (supplied
// value); a fill wins when both hit the same entry. Reset loads every entry
// with its sequential successor.
// Assumes fill_idx and rt_idx are below NUM_LINES.
module nlp_table #(
    parameter int NUM_LINES = 64,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic             rt_en,
    input  logic [IDX_W-1:0] rt_idx,
    input  logic [IDX_W-1:0] rt_val,
    output logic [IDX_W-1:0] entry_q [NUM_LINES]
);
    import nlp_pkg::*;

    logic [IDX_W-1:0] fill_val;

    // Sequential successor of the line being filled.
    always_comb begin
        fill_val = IDX_W'(seq_next(32'(fill_idx), NUM_LINES));
    end

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_entry
        localparam logic [IDX_W-1:0] SUCC = IDX_W'(seq_next(g, NUM_LINES));
        wr_src_e src;

        // Choose the write source for this entry, fill first.
        always_comb begin
            if (fill_en && fill_idx == IDX_W'(g))
                src = WR_FILL;
            else if (rt_en && rt_idx == IDX_W'(g))
                src = WR_RETRAIN;
            else
                src = WR_NONE;
        end

        // Entry register with reset to the sequential successor.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entry_q[g] <= SUCC;
            end else begin
                case (src)
                    WR_FILL:    entry_q[g] <= fill_val;
                    WR_RETRAIN: entry_q[g] <= rt_val;
                    default:    entry_q[g] <= entry_q[g];
                endcase
            end
        end
    end

endmodule

// File: rtl/nlp_compare.sv
// Module nlp_compare
// Compares the branch predictor's next line with the stored entry of the
// line it checked, and produces the squash flag and the retrain request.
// Assumes bp_line is below NUM_LINES.
module nlp_compare #(
    parameter int NUM_LINES = 64,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic             bp_valid,
    input  logic [IDX_W-1:0] bp_line,
    input  logic [IDX_W-1:0] bp_next,
    input  logic [IDX_W-1:0] entry_q [NUM_LINES],
    output logic             mismatch,
    output logic             rt_en,
    output logic [IDX_W-1:0] rt_idx,
    output logic [IDX_W-1:0] rt_val
);
    logic [IDX_W-1:0] stored;

    // Read the stored prediction of the checked line.
    always_comb begin
        stored = entry_q[bp_line];
    end

    // Flag a disagreement and request the retrain write.
    always_comb begin
        mismatch = bp_valid && (bp_next != stored);
        rt_en    = mismatch;
        rt_idx   = bp_line;
        rt_val   = bp_next;
    end

endmodule

// File: rtl/nlp_fetch_sel.sv
// Module nlp_fetch_sel
// Holds the fetch index. Each cycle it advances to the stored prediction of
// the current line, or to the branch predictor's line on a redirect.
// Assumes redirect_idx is below NUM_LINES.
module nlp_fetch_sel #(
    parameter int NUM_LINES = 64,
    parameter int RESET_IDX = 0,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] entry_q [NUM_LINES],
    input  logic             redirect,
    input  logic [IDX_W-1:0] redirect_idx,
    output logic [IDX_W-1:0] fetch_q
);
    logic [IDX_W-1:0] pred;
    logic [IDX_W-1:0] fetch_d;

    // Look up the prediction for the line fetched now.
    always_comb begin
        pred = entry_q[fetch_q];
    end

    // Redirect takes precedence over the line prediction.
    always_comb begin
        fetch_d = redirect ? redirect_idx : pred;
    end

    // Fetch index register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fetch_q <= IDX_W'(RESET_IDX);
        else
            fetch_q <= fetch_d;
    end

endmodule

// File: rtl/nlp_predictor.sv
// Module nlp_predictor
// Next-line index predictor: a table of per-line successor indices, a
// compare stage for branch predictor corrections and the fetch index
// register. Fill writes the sequential successor; a disagreeing compare
// squashes the current fetch, redirects and retrains.
// Assumes all index inputs are below NUM_LINES; NUM_LINES >= 2.
module nlp_predictor #(
    parameter int NUM_LINES = 64,
    parameter int RESET_IDX = 0,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_valid,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic             bp_valid,
    input  logic [IDX_W-1:0] bp_line,
    input  logic [IDX_W-1:0] bp_next,
    output logic [IDX_W-1:0] fetch_idx,
    output logic             squash
);
    logic [IDX_W-1:0] entries [NUM_LINES];
    logic             mismatch;
    logic             rt_en;
    logic [IDX_W-1:0] rt_idx;
    logic [IDX_W-1:0] rt_val;

    nlp_table #(.NUM_LINES(NUM_LINES)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .fill_en  (fill_valid),
        .fill_idx (fill_idx),
        .rt_en    (rt_en),
        .rt_idx   (rt_idx),
        .rt_val   (rt_val),
        .entry_q  (entries)
    );

    nlp_compare #(.NUM_LINES(NUM_LINES)) u_cmp (
        .bp_valid (bp_valid),
        .bp_line  (bp_line),
        .bp_next  (bp_next),
        .entry_q  (entries),
        .mismatch (mismatch),
        .rt_en    (rt_en),
        .rt_idx   (rt_idx),
        .rt_val   (rt_val)
    );

    nlp_fetch_sel #(.NUM_LINES(NUM_LINES), .RESET_IDX(RESET_IDX)) u_fetch (
        .clk          (clk),
        .rst_n        (rst_n),
        .entry_q      (entries),
        .redirect     (mismatch),
        .redirect_idx (bp_next),
        .fetch_q      (fetch_idx)
    );

    // Drive the squash output from the compare stage.
    always_comb begin
        squash = mismatch;
    end

endmodule

// File: rtl/nlp_predictor_chk.sv
// Module nlp_predictor_chk
// Assertion checker for nlp_predictor, attached by bind. Observes the ports
// and the table contents and checks the update and redirect rules.
// Assumes all index inputs are below NUM_LINES.
module nlp_predictor_chk #(
    parameter int NUM_LINES = 64,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fill_valid,
    input logic [IDX_W-1:0] fill_idx,
    input logic             bp_valid,
    input logic [IDX_W-1:0] bp_line,
    input logic [IDX_W-1:0] bp_next,
    input logic [IDX_W-1:0] fetch_idx,
    input logic             squash,
    input logic [IDX_W-1:0] entries [NUM_LINES]
);
    import nlp_pkg::*;

    logic [IDX_W-1:0] cur_pred;
    logic             prev_fill_v;
    logic [IDX_W-1:0] prev_fill_idx;
    logic [IDX_W-1:0] prev_fill_succ;
    logic             prev_rt_v;
    logic [IDX_W-1:0] prev_rt_idx;
    logic [IDX_W-1:0] prev_rt_val;

    // Prediction of the line fetched now, as stored in the table.
    always_comb begin
        cur_pred = entries[fetch_idx];
    end

    // Remember last cycle's fill and retrain for the write checks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_fill_v    <= 1'b0;
            prev_fill_idx  <= '0;
            prev_fill_succ <= '0;
            prev_rt_v      <= 1'b0;
            prev_rt_idx    <= '0;
            prev_rt_val    <= '0;
        end else begin
            prev_fill_v    <= fill_valid;
            prev_fill_idx  <= fill_idx;
            prev_fill_succ <= IDX_W'(seq_next(32'(fill_idx), NUM_LINES));
            prev_rt_v      <= squash;
            prev_rt_idx    <= bp_line;
            prev_rt_val    <= bp_next;
        end
    end

    assert_no_squash_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bp_valid |-> !squash);

    assert_redirect_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
        squash |=> fetch_idx == $past(bp_next));

    assert_follow_prediction_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !squash |=> fetch_idx == $past(cur_pred));

    // R3 and R7: a fill always leaves the successor, even against a retrain.
    assert_fill_successor_R3: assert property (@(posedge clk) disable iff (!rst_n)
        prev_fill_v |-> entries[prev_fill_idx] == prev_fill_succ);

    assert_retrain_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_rt_v && !(prev_fill_v && prev_fill_idx == prev_rt_idx))
            |-> entries[prev_rt_idx] == prev_rt_val);

endmodule

bind nlp_predictor nlp_predictor_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fill_valid (fill_valid),
    .fill_idx   (fill_idx),
    .bp_valid   (bp_valid),
    .bp_line    (bp_line),
    .bp_next    (bp_next),
    .fetch_idx  (fetch_idx),
    .squash     (squash),
    .entries    (entries)
);

// File: tb/nlp_predictor_bench.sv
module nlp_predictor_bench;
    localparam int NL = 64;
    localparam int IW = $clog2(NL);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fill_valid = 1'b0;
    logic [IW-1:0] fill_idx = '0;
    logic          bp_valid = 1'b0;
    logic [IW-1:0] bp_line = '0;
    logic [IW-1:0] bp_next = '0;
    logic [IW-1:0] fetch_idx;
    logic          squash;

    int checks = 0;
    int fails  = 0;
    int model [NL];
    int m_fetch;

    always #5 clk = ~clk;

    nlp_predictor #(.NUM_LINES(NL)) u_nlp_predictor (
        .clk(clk), .rst_n(rst_n),
        .fill_valid(fill_valid), .fill_idx(fill_idx),
        .bp_valid(bp_valid), .bp_line(bp_line), .bp_next(bp_next),
        .fetch_idx(fetch_idx), .squash(squash)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, compare, then advance the model.
    task automatic step(input bit fv, input int fi, input bit bv, input int bi,
                        input int bn, input string ftag);
        bit exp_sq;
        int nf;
        fill_valid = fv; fill_idx = IW'(fi);
        bp_valid = bv; bp_line = IW'(bi); bp_next = IW'(bn);
        #1;
        exp_sq = bv && (bn != model[bi]);
        check(squash == exp_sq, exp_sq ? "R4 squash" : (bv ? "R6 squash" : "R9 squash"),
              int'(squash), int'(exp_sq));
        check(int'(fetch_idx) == m_fetch, ftag, int'(fetch_idx), m_fetch);
        nf = exp_sq ? bn : model[m_fetch];
        @(posedge clk);
        if (exp_sq) model[bi] = bn;
        if (fv) model[fi] = (fi + 1) % NL;
        m_fetch = nf;
        @(negedge clk);
    endtask

    task automatic idle(input string ftag);
        step(1'b0, 0, 1'b0, 0, 0, ftag);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        #1_000_000;
        $display("FAIL watchdog: actual timeout expected completion");
        checks++;
        fails++;
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < NL; i++) model[i] = (i + 1) % NL;
        m_fetch = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state and sequential walk, wrapping at the end (R8)
        for (int i = 0; i < NL + 2; i++)
            idle((m_fetch == 0 && i > 0) ? "R8 wrap" : (i == 0 ? "R1 reset" : "R1 walk"));

        // R4 and R5: disagreeing compare redirects and retrains entry 10
        step(1'b0, 0, 1'b1, 10, 40, "R2 fetch");
        idle("R4 redirect");
        idle("R2 after redirect");
        step(1'b0, 0, 1'b1, 50, 10, "R2 fetch");
        idle("R4 redirect to 10");
        idle("R5 retrained entry");

        // R3: fill restores sequential successor of line 50
        step(1'b1, 50, 1'b0, 0, 0, "R2 fetch");
        step(1'b0, 0, 1'b1, 3, 50, "R2 fetch");
        idle("R4 redirect to 50");
        idle("R3 fill successor");

        // R7: fill and retrain on line 7 together, fill wins
        step(1'b1, 7, 1'b1, 7, 30, "R2 fetch");
        step(1'b0, 0, 1'b1, 9, 7, "R2 fetch");
        idle("R4 redirect to 7");
        idle("R7 fill wins");

        // R6: agreeing compare changes nothing
        step(1'b0, 0, 1'b1, 20, model[20], "R2 fetch");
        idle("R6 no redirect");

        // R8: fill of the last line wraps to 0
        step(1'b1, NL - 1, 1'b0, 0, 0, "R2 fetch");
        step(1'b0, 0, 1'b1, 5, NL - 1, "R2 fetch");
        idle("R4 redirect to last");
        idle("R8 fill wrap");

        // R9: ignored compare fields while bp_valid is low
        step(1'b0, 0, 1'b0, 12, 33, "R9 fetch");
        idle("R9 no retrain");

        // Mixed random traffic
        for (int i = 0; i < 400; i++) begin
            bit fv = ($urandom % 4) == 0;
            bit bv = ($urandom % 3) == 0;
            int fi = $urandom % NL;
            int bi = $urandom % NL;
            int bn = ($urandom % 2) ? model[bi] : int'($urandom % NL);
            step(fv, fi, bv, bi, bn, "R2 random");
        end

        summary();
        $finish;
    end
endmodule